// File: doc/BRIEF.md
# Adaptive Transition-Code Bus Decoder

This block terminates a low-activity on-chip bus. The sender signals each word as changes on the data lines, not as levels. Frequent values travel as short codes with few set bits. The decoder recovers the original word from each bus beat in three steps:

- It takes the change on the data lines since the previous beat.
- It undoes the optional complement.
- If the beat carries a code, it looks up the value held at that code's rank.

It then reverses the sender's input filter, using the last word it decoded.

No codebook is fixed. The decoder keeps its own copy of the sender's frequency-ranked value table and updates it on every accepted beat with the same rules as the sender, so the two tables stay identical cycle for cycle. The filter is chosen by parameter: XOR with the previous word, or subtraction of the previous word. A decoded word appears one cycle after its beat. A code that cannot belong to a filled table entry raises a sticky error flag.

Top module: `transition_code_dec`

## Requirements
- R1: The payload of a beat is the current data lines XOR the data lines of the previous valid beat; the stored previous lines reset to zero and are updated on every valid beat.
- R2: When the invert line is high, the payload is complemented before any other use.
- R3: When the coded line is low, the payload itself is the filtered value.
- R4: In XOR filter mode the decoded word is the filtered value XOR the previous decoded word; the previous decoded word resets to zero.
- R5: In subtract filter mode the decoded word is the filtered value plus the previous decoded word, modulo 2^32.
- R6: Ranks map to codes as follows. Rank 0 is all zeros. Rank r from 1 to 32 has only bit r-1 set. Higher ranks are two-hot, with pairs (i<j) taken in order of increasing j and then increasing i. When the coded line is high, the filtered value is the value held at the matching rank.
- R7: A coded beat increments the counter (8 bits) of its rank. If that counter was 255, all counters are first halved. If the new count is strictly greater than the count at rank r-1, the two entries swap.
- R8: An uncoded beat overwrites the lowest rank (N_ENT-1) with the filtered value and a count of 1, marks it filled, and then applies the same swap rule.
- R9: valid_o pulses exactly one cycle after each valid beat, and data_o holds its value between decoded words.
- R10: A coded beat whose payload is no rank's code, or whose rank is empty, sets desync_o. desync_o then stays high until reset, and that beat changes neither the table nor the previous decoded word.
- R11: Reset clears valid_o, data_o and desync_o and empties the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus beat present |
| bus_data_i | input | DATA_W | Data lines (transition coded) |
| bus_coded_i | input | 1 | Payload is a rank code |
| bus_inv_i | input | 1 | Payload was complemented |
| valid_o | output | 1 | Decoded word strobe |
| data_o | output | DATA_W | Decoded word |
| desync_o | output | 1 | Sticky table mismatch error |

## Verification
The bench runs its own encoder model for both filter modes and expects every original word back. The test streams are chosen to separate behaviours:
- Random full-width words stay uncoded and exercise insertion at the lowest rank.
- Alternation between all-zeros and all-ones forces the complement path.
- A small repeating set of values exercises all zero and one-hot ranks and adjacent swaps.
- A long constant run drives a counter past 255 and forces halving.
- A counting sequence is coded only through the subtract filter, which tells the two unfilter variants apart.

Finally, an invalid three-hot code and a code that points at an empty entry must both raise the sticky error.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [0:0] {
    FILT_XOR = 1'b0,
    FILT_SUB = 1'b1
  } filt_mode_e;
endpackage

// File: rtl/tcd_code_dec.sv
module tcd_code_dec #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned RANK_W = 3
) (
  input  logic [DATA_W-1:0] payload_i,
  output logic              hit_o,
  output logic [RANK_W-1:0] rank_o
);
  // R6: zero, then one-hot, then two-hot ordered by high bit then low bit
  function automatic logic [DATA_W-1:0] rank_code(input int unsigned r);
    logic [DATA_W-1:0] c;
    int unsigned k;
    logic done;
    c = '0;
    done = 1'b0;
    if (r >= 1 && r <= DATA_W) begin
      c[r-1] = 1'b1;
    end else if (r > DATA_W) begin
      k = r - 1 - DATA_W;
      for (int j = 1; j < int'(DATA_W); j++) begin
        for (int i = 0; i < j; i++) begin
          if (!done) begin
            if (k == 0) begin
              c[i] = 1'b1;
              c[j] = 1'b1;
              done = 1'b1;
            end else begin
              k = k - 1;
            end
          end
        end
      end
    end
    return c;
  endfunction

  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < int'(N_ENT); g++) begin : g_cmp
    localparam logic [DATA_W-1:0] CODE = rank_code(g);
    assign match[g] = (payload_i == CODE);
  end

  always_comb begin
    hit_o  = 1'b0;
    rank_o = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (match[i] && !hit_o) begin
        hit_o  = 1'b1;
        rank_o = RANK_W'(i);
      end
    end
  end
endmodule

// File: rtl/tcd_rank_table.sv
module tcd_rank_table #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned RANK_W = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           upd_i,
  input  logic                           hit_i,
  input  logic [RANK_W-1:0]              rank_i,
  input  logic [DATA_W-1:0]              new_val_i,
  output logic [N_ENT-1:0][DATA_W-1:0]   val_o,
  output logic [N_ENT-1:0]               vld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] val_q [N_ENT];
  logic [DATA_W-1:0] val_d [N_ENT];
  logic [CNT_W-1:0]  cnt_q [N_ENT];
  logic [CNT_W-1:0]  cnt_d [N_ENT];
  logic [N_ENT-1:0]  vld_q, vld_d;

  always_comb begin
    logic [DATA_W-1:0] tv;
    logic [CNT_W-1:0]  tc;
    logic              tb;
    int                t;
    val_d = val_q;
    cnt_d = cnt_q;
    vld_d = vld_q;
    tv = '0;
    tc = '0;
    tb = 1'b0;
    t  = hit_i ? int'(rank_i) : int'(N_ENT) - 1;
    if (upd_i) begin
      if (hit_i) begin
        // R7: saturating hit halves every counter first
        if (cnt_q[t] == CNT_MAX) begin
          for (int i = 0; i < int'(N_ENT); i++) cnt_d[i] = cnt_q[i] >> 1;
        end
        cnt_d[t] = cnt_d[t] + 1'b1;
      end else begin
        // R8: newcomer enters at the lowest rank
        val_d[t] = new_val_i;
        cnt_d[t] = CNT_W'(1);
        vld_d[t] = 1'b1;
      end
      if (t > 0 && cnt_d[t] > cnt_d[t-1]) begin
        tv = val_d[t]; val_d[t] = val_d[t-1]; val_d[t-1] = tv;
        tc = cnt_d[t]; cnt_d[t] = cnt_d[t-1]; cnt_d[t-1] = tc;
        tb = vld_d[t]; vld_d[t] = vld_d[t-1]; vld_d[t-1] = tb;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_ENT); i++) begin
        val_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      vld_q <= '0;
    end else begin
      val_q <= val_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  for (genvar g = 0; g < int'(N_ENT); g++) begin : g_out
    assign val_o[g] = val_q[g];

    // R11
    empty_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_q[g] |-> cnt_q[g] == '0);
  end
  assign vld_o = vld_q;

  // R8
  fill_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(vld_q) >= $countones($past(vld_q)));
endmodule

// File: rtl/tcd_unfilter.sv
module tcd_unfilter
  import tcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter filt_mode_e  FILT   = FILT_XOR
) (
  input  logic [DATA_W-1:0] filt_i,
  input  logic [DATA_W-1:0] prev_i,
  output logic [DATA_W-1:0] word_o
);
  if (FILT == FILT_SUB) begin : g_sub
    assign word_o = filt_i + prev_i;  // R5
  end else begin : g_xor
    assign word_o = filt_i ^ prev_i;  // R4
  end
endmodule

// File: rtl/transition_code_dec.sv
module transition_code_dec
  import tcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter filt_mode_e  FILT   = FILT_XOR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_coded_i,
  input  logic              bus_inv_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              desync_o
);
  localparam int unsigned RANK_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [DATA_W-1:0]             prev_bus_q, prev_out_q, data_q;
  logic                          valid_q, desync_q;
  logic [DATA_W-1:0]             payload, filtered, unf;
  logic                          hit, entry_ok, bad, upd;
  logic [RANK_W-1:0]             rank;
  logic [N_ENT-1:0][DATA_W-1:0]  tab_val;
  logic [N_ENT-1:0]              tab_vld;

  // R1, R2
  assign payload  = (bus_data_i ^ prev_bus_q) ^ {DATA_W{bus_inv_i}};

  tcd_code_dec #(.DATA_W(DATA_W), .N_ENT(N_ENT), .RANK_W(RANK_W)) u_code_dec (
    .payload_i (payload),
    .hit_o     (hit),
    .rank_o    (rank)
  );

  assign entry_ok = hit && tab_vld[rank];
  assign bad      = valid_i && bus_coded_i && !entry_ok;
  assign upd      = valid_i && !bad;
  // R3, R6
  assign filtered = bus_coded_i ? tab_val[rank] : payload;

  tcd_unfilter #(.DATA_W(DATA_W), .FILT(FILT)) u_unfilter (
    .filt_i (filtered),
    .prev_i (prev_out_q),
    .word_o (unf)
  );

  tcd_rank_table #(.DATA_W(DATA_W), .N_ENT(N_ENT), .CNT_W(CNT_W), .RANK_W(RANK_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .hit_i     (bus_coded_i),
    .rank_i    (rank),
    .new_val_i (payload),
    .val_o     (tab_val),
    .vld_o     (tab_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_bus_q <= '0;
      prev_out_q <= '0;
      data_q     <= '0;
      valid_q    <= 1'b0;
      desync_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) prev_bus_q <= bus_data_i;
      if (upd) begin
        data_q     <= unf;
        prev_out_q <= unf;
      end
      if (bad) desync_q <= 1'b1;
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign desync_o = desync_q;

  // R9
  strobe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  no_spurious_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R10
  desync_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desync_o |=> desync_o);
  // R10
  desync_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desync_o) |-> $past(valid_i && bus_coded_i));
endmodule

// File: tb/transition_code_dec_tb.sv
module transition_code_dec_tb;
  import tcd_pkg::*;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v   [2];
  logic [31:0] bd  [2];
  logic        bc  [2];
  logic        bi  [2];
  logic        vo  [2];
  logic [31:0] dout[2];
  logic        dsy [2];

  transition_code_dec #(.FILT(FILT_XOR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v[0]), .bus_data_i(bd[0]),
    .bus_coded_i(bc[0]), .bus_inv_i(bi[0]), .valid_o(vo[0]),
    .data_o(dout[0]), .desync_o(dsy[0]));

  transition_code_dec #(.FILT(FILT_SUB)) u_dut_sub (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v[1]), .bus_data_i(bd[1]),
    .bus_coded_i(bc[1]), .bus_inv_i(bi[1]), .valid_o(vo[1]),
    .data_o(dout[1]), .desync_o(dsy[1]));

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b1;

  logic [31:0] exp_q0[$], exp_q1[$];
  string       tag_q0[$], tag_q1[$];

  // encoder model state, one set per filter mode
  logic [31:0] m_val [2][N];
  int          m_cnt [2][N];
  bit          m_vld [2][N];
  logic [31:0] m_bus [2];
  logic [31:0] m_prev[2];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] tb_code(input int r);
    int k;
    if (r == 0) return 32'h0;
    if (r <= 32) return 32'h1 << (r - 1);
    k = r - 33;
    for (int j = 1; j < 32; j++)
      for (int i = 0; i < j; i++) begin
        if (k == 0) return (32'h1 << i) | (32'h1 << j);
        k--;
      end
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_bus[m] = '0;
      m_prev[m] = '0;
      for (int i = 0; i < N; i++) begin
        m_val[m][i] = '0; m_cnt[m][i] = 0; m_vld[m][i] = 1'b0;
      end
    end
  endtask

  task automatic model_update(input int m, input bit coded, input int r, input logic [31:0] f);
    int t;
    logic [31:0] tv; int tc; bit tb;
    if (coded) begin
      if (m_cnt[m][r] == 255)
        for (int i = 0; i < N; i++) m_cnt[m][i] = m_cnt[m][i] / 2;
      m_cnt[m][r]++;
      t = r;
    end else begin
      t = N - 1;
      m_val[m][t] = f; m_cnt[m][t] = 1; m_vld[m][t] = 1'b1;
    end
    if (t > 0 && m_cnt[m][t] > m_cnt[m][t-1]) begin
      tv = m_val[m][t]; m_val[m][t] = m_val[m][t-1]; m_val[m][t-1] = tv;
      tc = m_cnt[m][t]; m_cnt[m][t] = m_cnt[m][t-1]; m_cnt[m][t-1] = tc;
      tb = m_vld[m][t]; m_vld[m][t] = m_vld[m][t-1]; m_vld[m][t-1] = tb;
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    logic [31:0] f, p;
    bit coded, inv;
    int r;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      f = (m == 0) ? (w ^ m_prev[m]) : (w - m_prev[m]);
      coded = 1'b0; r = 0;
      for (int i = 0; i < N; i++)
        if (!coded && m_vld[m][i] && m_val[m][i] == f) begin coded = 1'b1; r = i; end
      p = coded ? tb_code(r) : f;
      inv = ($countones(p) > 16);
      if (inv) p = ~p;
      m_bus[m] = m_bus[m] ^ p;
      v[m] = 1'b1; bd[m] = m_bus[m]; bc[m] = coded; bi[m] = inv;
      model_update(m, coded, r, f);
      m_prev[m] = w;
    end
    exp_q0.push_back(w); tag_q0.push_back(tag);
    exp_q1.push_back(w); tag_q1.push_back((tag == "R4") ? "R5" : tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin v[m] = 1'b0; bc[m] = 1'b0; bi[m] = 1'b0; end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (vo[0]) begin
        if (exp_q0.size() == 0) check(1'b0, "R9", {31'b0, vo[0]}, 32'h0);
        else check(dout[0] == exp_q0[0], tag_q0[0], dout[0], exp_q0[0]);
        if (exp_q0.size() != 0) begin void'(exp_q0.pop_front()); void'(tag_q0.pop_front()); end
      end
      if (vo[1]) begin
        if (exp_q1.size() == 0) check(1'b0, "R9", {31'b0, vo[1]}, 32'h0);
        else check(dout[1] == exp_q1[0], tag_q1[0], dout[1], exp_q1[0]);
        if (exp_q1.size() != 0) begin void'(exp_q1.pop_front()); void'(tag_q1.pop_front()); end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [31:0] set6 [6];
  logic [31:0] w;
  logic [31:0] held;

  initial begin
    set6[0] = 32'h0000_1000; set6[1] = 32'h0000_1004; set6[2] = 32'h0000_1008;
    set6[3] = 32'h0000_2000; set6[4] = 32'h0000_1010; set6[5] = 32'h0000_100c;
    for (int m = 0; m < 2; m++) begin v[m] = 0; bd[m] = '0; bc[m] = 0; bi[m] = 0; end
    model_reset();
    repeat (2) @(negedge clk);
    // R11 reset state
    check(vo[0] == 0 && vo[1] == 0, "R11", {31'b0, vo[0]}, 32'h0);
    check(dout[0] == 0, "R11", dout[0], 32'h0);
    check(dsy[0] == 0 && dsy[1] == 0, "R11", {31'b0, dsy[0]}, 32'h0);
    rst_n = 1'b1;
    idle(1);

    // R1, R3: first word from empty table, then R9 latency and hold
    send(32'h1234_5678, "R1");
    @(negedge clk);
    for (int m = 0; m < 2; m++) v[m] = 1'b0;
    check(vo[0] == 1'b1, "R9", {31'b0, vo[0]}, 32'h1);
    held = dout[0];
    idle(2);
    check(vo[0] == 1'b0, "R9", {31'b0, vo[0]}, 32'h0);
    check(dout[0] == held, "R9", dout[0], held);

    // R3, R8: random uncoded words
    for (int i = 0; i < 20; i++) send($urandom(), "R8");
    idle(1);

    // R2: full complement swings force the invert line
    for (int i = 0; i < 16; i++) send((i % 2) ? 32'hffff_ffff : 32'h0, "R2");
    idle(1);

    // R6, R7: small repeating set fills all ranks and drives swaps
    for (int i = 0; i < 200; i++) send(set6[(i * 7 + i / 3) % 6], "R6");
    idle(2);

    // R7: long constant run saturates a counter
    w = 32'hcafe_0001;
    for (int i = 0; i < 300; i++) send(w, "R7");
    idle(1);

    // R8: replacement after a settled table, then reuse
    for (int i = 0; i < 12; i++) send($urandom(), "R8");
    for (int i = 0; i < 80; i++) send(set6[i % 6], "R6");
    idle(1);

    // R4 / R5: counting sequence, constant step under subtraction
    for (int i = 0; i < 150; i++) send(32'h0100_0000 + i, "R4");
    idle(3);
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R9", exp_q0.size(), 32'h0);

    // R10: three-hot payload is no rank code
    mon_en = 1'b0;
    @(negedge clk);
    v[0] = 1'b1; bc[0] = 1'b1; bi[0] = 1'b0; bd[0] = m_bus[0] ^ 32'h7;
    idle(1);
    check(dsy[0] == 1'b1, "R10", {31'b0, dsy[0]}, 32'h1);
    check(dsy[1] == 1'b0, "R10", {31'b0, dsy[1]}, 32'h0);
    @(negedge clk);
    v[0] = 1'b1; bc[0] = 1'b0; bd[0] = 32'h5;
    idle(3);
    check(dsy[0] == 1'b1, "R10", {31'b0, dsy[0]}, 32'h1);

    // R11: reset clears everything again
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check(dsy[0] == 1'b0, "R11", {31'b0, dsy[0]}, 32'h0);
    check(dout[0] == 0 && dout[1] == 0, "R11", dout[0], 32'h0);
    check(vo[0] == 0, "R11", {31'b0, vo[0]}, 32'h0);
    rst_n = 1'b1;
    idle(1);

    // R10: code of rank 5 while the table is empty
    @(negedge clk);
    v[0] = 1'b1; bc[0] = 1'b1; bi[0] = 1'b0; bd[0] = tb_code(5);
    idle(1);
    check(dsy[0] == 1'b1, "R10", {31'b0, dsy[0]}, 32'h1);
    check(dout[0] == 32'h0, "R10", dout[0], 32'h0);
    idle(2);
    finish_run();
  end
endmodule